// File: doc/BRIEF.md
# Serial Channel Status and Flag Capture

This block collects the status of one serial transceiver channel into a single 32-bit word. A receiver, a transmitter and a timeout counter report their events as one-cycle pulses. The block turns each event into a flag that stays set, watches four modem-control lines for level changes, and adds live views of transmitter occupancy and of the receive-DMA buffer-full level. The word is always visible on a read-data port. Software clears flags through three separate paths: the read strobe clears the modem-change flags, an error-reset command clears the error group, and a separate command clears only the NACK flag.

A mask register with the same bit layout selects which status bits raise the interrupt output. One status bit changes meaning with the operating mode. In SPI slave mode it reports a transmit underrun. In every other mode it reports that the repetition limit was reached. When a flag is set and cleared in the same cycle, the set wins, so no event is lost.

Top module: `serial_status_hub`

## Requirements
- R1: A level change on a modem line (index 0 cts, 1 dcd, 2 dsr, 3 ri) presented before rising edge k is reported in its change flag (bits 16, 17, 18, 19) after edge k+2. This follows from two synchronizer stages and one compare stage.
- R2: A change flag stays set until a cycle in which `rd_en` is high. It reads 0 after that edge. The error-reset command does not clear it.
- R3: Bit 24 shows the synchronized ri level. A change presented before edge k appears after edge k+1.
- R4: Parity (bit 4), framing (bit 5), overrun (bit 6) and break (bit 7) flags set on their event pulse. They stay set until `rst_err_cmd` and are not cleared by `rst_nack_cmd`.
- R5: The NACK flag (bit 10) sets on `rx_nack`. Only `rst_nack_cmd` clears it; `rst_err_cmd` leaves it set.
- R6: Bit 9 is sticky and is cleared by `rst_err_cmd`. When `mode_sel` is 4'hF, only `spi_underrun` sets it. In any other mode, only `rep_limit` sets it.
- R7: The timeout flag (bit 8) sets on `tmo_expire` only when `tmo_start` has been seen since the last expiry. The next `tmo_start` clears it. It stays 0 in any cycle where `tmo_zero` is high.
- R8: Bit 0 (ready) is 1 when `tx_en` is high and both `hold_busy` and `brk_req` are low. Bit 1 (empty) is 1 when `tx_en` is high and both `hold_busy` and `shift_busy` are low. Both bits are combinational.
- R9: Bit 2 mirrors `rxdma_full` combinationally, with no latching.
- R10: When a flag's set event and its clear (read or command) fall in the same cycle, the flag is 1 afterwards.
- R11: `irq` is the OR of `rd_data & mask`. A `mask_we` pulse loads `mask_wdata` into the mask at the edge.
- R12: After reset, every flag and the mask are 0. With inputs low, `rd_data` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 4 | Operating mode; 4'hF selects SPI slave |
| tx_en | input | 1 | Transmitter enabled |
| hold_busy | input | 1 | Holding register occupied |
| shift_busy | input | 1 | Transmit shift register occupied |
| brk_req | input | 1 | Start-break request pending |
| rx_parity_err | input | 1 | Parity error pulse |
| rx_frame_err | input | 1 | Stop bit sampled low pulse |
| rx_overrun | input | 1 | Overrun pulse |
| rx_break | input | 1 | Break start or end pulse |
| rx_nack | input | 1 | Non-acknowledge pulse |
| rep_limit | input | 1 | Repetition limit reached pulse |
| spi_underrun | input | 1 | SPI slave underrun pulse |
| tmo_start | input | 1 | Start-timeout command pulse |
| tmo_expire | input | 1 | Timeout counter expiry pulse |
| tmo_zero | input | 1 | Programmed timeout value is zero |
| rst_err_cmd | input | 1 | Clear error group command |
| rst_nack_cmd | input | 1 | Clear NACK command |
| rxdma_full | input | 1 | Receive DMA buffer-full level |
| cts_pin | input | 1 | Modem line, clear to send |
| dcd_pin | input | 1 | Modem line, carrier detect |
| dsr_pin | input | 1 | Modem line, data set ready |
| ri_pin | input | 1 | Modem line, ring indicator |
| rd_en | input | 1 | Status read strobe |
| rd_data | output | 32 | Status word |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 32 | Mask write data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check every cycle that each flag holds without a clear, that a set event wins over a simultaneous clear, that a quiet read clears a change flag, that a zero timeout keeps its flag low, and that empty implies ready when no break is pending. Only the bench scenarios can show the exact latency of the modem path, the mode-dependent meaning of bit 9, the arming rule for the timeout, and which command clears which group. The bench also shows the interrupt following the mask through both latched and live bits.

// File: rtl/sstat_pkg.sv
package sstat_pkg;

    localparam int WORD_W        = 32;
    localparam int MODE_W        = 4;
    localparam int MODEM_LANES   = 4;

    // status word bit positions
    localparam int POS_TXRDY     = 0;
    localparam int POS_TXEMPTY   = 1;
    localparam int POS_RXBUF     = 2;
    localparam int POS_PARITY    = 4;
    localparam int POS_FRAMING   = 5;
    localparam int POS_OVERRUN   = 6;
    localparam int POS_BREAK     = 7;
    localparam int POS_TIMEOUT   = 8;
    localparam int POS_SHARED    = 9;
    localparam int POS_NACK      = 10;
    localparam int POS_MCHG_BASE = 16;
    localparam int POS_RI_LVL    = 24;

    // lane index of the ring-indicator line
    localparam int LANE_RI       = 3;

    typedef struct packed {
        logic parity;
        logic framing;
        logic overrun;
        logic brk;
        logic shared;
        logic nack;
        logic timeout;
    } flag_set_t;

endpackage

// File: rtl/sstat_modem_watch.sv
module sstat_modem_watch #(
    parameter int LANES  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] pins,
    input  logic             clr,
    output logic [LANES-1:0] level,
    output logic [LANES-1:0] changed
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][LANES-1:0] sync;
        logic [LANES-1:0]             prev;
        logic [LANES-1:0]             chg;
    } st_t;

    st_t cur_q, nxt_d;
    logic [LANES-1:0] edge_w;

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.sync[0] = pins;
        for (int i = 1; i < STAGES; i++) begin
            nxt_d.sync[i] = cur_q.sync[i-1];
        end
        edge_w     = cur_q.sync[LAST] ^ cur_q.prev;
        nxt_d.prev = cur_q.sync[LAST];
        // a detected edge wins over a clearing read
        nxt_d.chg  = edge_w | (cur_q.chg & ~{LANES{clr}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign level   = cur_q.sync[LAST];
    assign changed = cur_q.chg;

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R1 / R10: an edge always lands in the flag
        a_r1_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (cur_q.sync[LAST][g] != cur_q.prev[g]) |=> cur_q.chg[g]);
        // R2: the flag holds without a read
        a_r2_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (cur_q.chg[g] && !clr) |=> cur_q.chg[g]);
        // R2: a quiet read clears the flag
        a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && (cur_q.sync[LAST][g] == cur_q.prev[g])) |=> !cur_q.chg[g]);
    end

endmodule

// File: rtl/sstat_flag_bank.sv
module sstat_flag_bank
    import sstat_pkg::*;
#(
    parameter int                MODE_BITS = MODE_W,
    parameter logic [MODE_W-1:0] SPI_SLAVE = 4'hF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MODE_BITS-1:0] mode,
    input  logic                 ev_parity,
    input  logic                 ev_framing,
    input  logic                 ev_overrun,
    input  logic                 ev_break,
    input  logic                 ev_nack,
    input  logic                 ev_repeat,
    input  logic                 ev_underrun,
    input  logic                 clr_err,
    input  logic                 clr_nack,
    input  logic                 tmo_start,
    input  logic                 tmo_expire,
    input  logic                 tmo_zero,
    output flag_set_t            flags
);

    typedef struct packed {
        flag_set_t f;
        logic      armed;
    } st_t;

    st_t  cur_q, nxt_d;
    logic spi_mode;
    logic shared_ev;

    always_comb begin
        nxt_d     = cur_q;
        spi_mode  = (mode == MODE_BITS'(SPI_SLAVE));
        shared_ev = spi_mode ? ev_underrun : ev_repeat;

        // error group: set has priority over the clear command
        nxt_d.f.parity  = ev_parity  | (cur_q.f.parity  & ~clr_err);
        nxt_d.f.framing = ev_framing | (cur_q.f.framing & ~clr_err);
        nxt_d.f.overrun = ev_overrun | (cur_q.f.overrun & ~clr_err);
        nxt_d.f.brk     = ev_break   | (cur_q.f.brk     & ~clr_err);
        nxt_d.f.shared  = shared_ev  | (cur_q.f.shared  & ~clr_err);

        // NACK has its own clear
        nxt_d.f.nack    = ev_nack    | (cur_q.f.nack    & ~clr_nack);

        // timeout: armed by a start, consumed by an expiry
        nxt_d.armed     = tmo_start | (cur_q.armed & ~tmo_expire);
        if (tmo_zero) begin
            nxt_d.f.timeout = 1'b0;
        end else begin
            nxt_d.f.timeout = (tmo_expire & cur_q.armed)
                            | (cur_q.f.timeout & ~tmo_start);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign flags = cur_q.f;

    // R4: error flags hold until the error-reset command
    a_r4_parity_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.f.parity && !clr_err) |=> cur_q.f.parity);
    a_r4_break_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.f.brk && !clr_err) |=> cur_q.f.brk);
    // R10: set beats clear
    a_r10_framing_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev_framing |=> cur_q.f.framing);
    // R5: NACK untouched by the error-reset command
    a_r5_nack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.f.nack && !clr_nack) |=> cur_q.f.nack);
    // R6: in SPI slave mode a repetition event alone cannot set bit 9
    a_r6_spi_ignores_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_mode && !ev_underrun && !cur_q.f.shared) |=> !cur_q.f.shared);
    // R7: zero timeout value keeps the flag low
    a_r7_zero_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_zero |=> !cur_q.f.timeout);
    // R7: without arming, an expiry cannot raise the flag
    a_r7_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_q.armed && !cur_q.f.timeout) |=> !cur_q.f.timeout);

endmodule

// File: rtl/serial_status_hub.sv
module serial_status_hub
    import sstat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              tx_en,
    input  logic              hold_busy,
    input  logic              shift_busy,
    input  logic              brk_req,
    input  logic              rx_parity_err,
    input  logic              rx_frame_err,
    input  logic              rx_overrun,
    input  logic              rx_break,
    input  logic              rx_nack,
    input  logic              rep_limit,
    input  logic              spi_underrun,
    input  logic              tmo_start,
    input  logic              tmo_expire,
    input  logic              tmo_zero,
    input  logic              rst_err_cmd,
    input  logic              rst_nack_cmd,
    input  logic              rxdma_full,
    input  logic              cts_pin,
    input  logic              dcd_pin,
    input  logic              dsr_pin,
    input  logic              ri_pin,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic              mask_we,
    input  logic [WORD_W-1:0] mask_wdata,
    output logic              irq
);

    typedef struct packed {
        logic [WORD_W-1:0] mask;
    } st_t;

    st_t                    cur_q, nxt_d;
    flag_set_t              flags;
    logic [MODEM_LANES-1:0] mlvl;
    logic [MODEM_LANES-1:0] mchg;
    logic [WORD_W-1:0]      status_w;

    sstat_modem_watch #(
        .LANES  (MODEM_LANES),
        .STAGES (SYNC_STAGES)
    ) u_modem (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins    ({ri_pin, dsr_pin, dcd_pin, cts_pin}),
        .clr     (rd_en),
        .level   (mlvl),
        .changed (mchg)
    );

    sstat_flag_bank #(
        .MODE_BITS (MODE_W),
        .SPI_SLAVE (4'hF)
    ) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_sel),
        .ev_parity   (rx_parity_err),
        .ev_framing  (rx_frame_err),
        .ev_overrun  (rx_overrun),
        .ev_break    (rx_break),
        .ev_nack     (rx_nack),
        .ev_repeat   (rep_limit),
        .ev_underrun (spi_underrun),
        .clr_err     (rst_err_cmd),
        .clr_nack    (rst_nack_cmd),
        .tmo_start   (tmo_start),
        .tmo_expire  (tmo_expire),
        .tmo_zero    (tmo_zero),
        .flags       (flags)
    );

    // status word assembly
    always_comb begin
        status_w              = '0;
        status_w[POS_TXRDY]   = tx_en & ~hold_busy & ~brk_req;
        status_w[POS_TXEMPTY] = tx_en & ~hold_busy & ~shift_busy;
        status_w[POS_RXBUF]   = rxdma_full;
        status_w[POS_PARITY]  = flags.parity;
        status_w[POS_FRAMING] = flags.framing;
        status_w[POS_OVERRUN] = flags.overrun;
        status_w[POS_BREAK]   = flags.brk;
        status_w[POS_TIMEOUT] = flags.timeout;
        status_w[POS_SHARED]  = flags.shared;
        status_w[POS_NACK]    = flags.nack;
        for (int i = 0; i < MODEM_LANES; i++) begin
            status_w[POS_MCHG_BASE + i] = mchg[i];
        end
        status_w[POS_RI_LVL]  = mlvl[LANE_RI];
    end

    always_comb begin
        nxt_d = cur_q;
        if (mask_we) nxt_d.mask = mask_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rd_data = status_w;
    assign irq     = |(status_w & cur_q.mask);

    // R11: mask captures the written value
    a_r11_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (cur_q.mask == $past(mask_wdata)));
    // R8: empty transmitter with no break pending is also ready
    a_r8_empty_implies_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[POS_TXEMPTY] && !brk_req) |-> rd_data[POS_TXRDY]);

endmodule

// File: tb/test_serial_status_hub.sv
module test_serial_status_hub;

    localparam int B_RDY = 0, B_EMP = 1, B_RXB = 2, B_PAR = 4, B_FRM = 5;
    localparam int B_OVR = 6, B_BRK = 7, B_TMO = 8, B_SHR = 9, B_NAK = 10;
    localparam int B_CTS = 16, B_DCD = 17, B_DSR = 18, B_RIC = 19, B_RIL = 24;
    localparam int B_IRQ = 32;

    localparam int E_PAR = 0, E_FRM = 1, E_OVR = 2, E_BRK = 3, E_NAK = 4;
    localparam int E_REP = 5, E_UND = 6, E_TS = 7, E_TE = 8, E_RERR = 9;
    localparam int E_RNAK = 10, E_RD = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode_sel = 4'h0;
    logic        tx_en = 0, hold_busy = 0, shift_busy = 0, brk_req = 0;
    logic        rx_parity_err = 0, rx_frame_err = 0, rx_overrun = 0, rx_break = 0;
    logic        rx_nack = 0, rep_limit = 0, spi_underrun = 0;
    logic        tmo_start = 0, tmo_expire = 0, tmo_zero = 0;
    logic        rst_err_cmd = 0, rst_nack_cmd = 0, rxdma_full = 0;
    logic        cts_pin = 0, dcd_pin = 0, dsr_pin = 0, ri_pin = 0;
    logic        rd_en = 0, mask_we = 0;
    logic [31:0] mask_wdata = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic [32:0] q_val[$];
    logic [32:0] q_msk[$];
    string       q_tag[$];

    always #10 clk = ~clk;

    serial_status_hub i_serial_status_hub (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .tx_en(tx_en),
        .hold_busy(hold_busy), .shift_busy(shift_busy), .brk_req(brk_req),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
        .rx_overrun(rx_overrun), .rx_break(rx_break), .rx_nack(rx_nack),
        .rep_limit(rep_limit), .spi_underrun(spi_underrun),
        .tmo_start(tmo_start), .tmo_expire(tmo_expire), .tmo_zero(tmo_zero),
        .rst_err_cmd(rst_err_cmd), .rst_nack_cmd(rst_nack_cmd),
        .rxdma_full(rxdma_full), .cts_pin(cts_pin), .dcd_pin(dcd_pin),
        .dsr_pin(dsr_pin), .ri_pin(ri_pin), .rd_en(rd_en), .rd_data(rd_data),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .irq(irq)
    );

    function automatic logic [32:0] bm(input int pos);
        return 33'(1) << pos;
    endfunction

    // monitor: compares one expected item per falling edge
    always @(negedge clk) begin
        if (q_val.size() > 0) begin
            logic [32:0] m, v, a;
            string       t;
            m = q_msk.pop_front();
            v = q_val.pop_front();
            t = q_tag.pop_front();
            a = {irq, rd_data};
            n_chk++;
            if ((a & m) != (v & m)) begin
                n_err++;
                $display("FAIL %s: actual %h expected %h (mask %h)", t, a & m, v & m, m);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // driver: queue an expectation, let the monitor consume it
    task automatic push_exp(input logic [32:0] m, input logic [32:0] v, input string t);
        q_msk.push_back(m);
        q_val.push_back(v);
        q_tag.push_back(t);
        @(negedge clk);
        #1;
    endtask

    task automatic fire(input int which);
        case (which)
            E_PAR:  rx_parity_err = 1;
            E_FRM:  rx_frame_err  = 1;
            E_OVR:  rx_overrun    = 1;
            E_BRK:  rx_break      = 1;
            E_NAK:  rx_nack       = 1;
            E_REP:  rep_limit     = 1;
            E_UND:  spi_underrun  = 1;
            E_TS:   tmo_start     = 1;
            E_TE:   tmo_expire    = 1;
            E_RERR: rst_err_cmd   = 1;
            E_RNAK: rst_nack_cmd  = 1;
            default: rd_en        = 1;
        endcase
        step(1);
        rx_parity_err = 0; rx_frame_err = 0; rx_overrun = 0; rx_break = 0;
        rx_nack = 0; rep_limit = 0; spi_underrun = 0; tmo_start = 0;
        tmo_expire = 0; rst_err_cmd = 0; rst_nack_cmd = 0; rd_en = 0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [32:0] errs;
        errs = bm(B_PAR) | bm(B_FRM) | bm(B_OVR) | bm(B_BRK);
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        step(1);

        // R12 reset state
        push_exp({33{1'b1}}, 33'h0, "R12 reset word and irq");

        // R8 transmitter occupancy
        tx_en = 1;
        push_exp(bm(B_RDY) | bm(B_EMP), bm(B_RDY) | bm(B_EMP), "R8 idle enabled");
        hold_busy = 1;
        push_exp(bm(B_RDY) | bm(B_EMP), 33'h0, "R8 holding busy");
        hold_busy = 0; shift_busy = 1;
        push_exp(bm(B_RDY) | bm(B_EMP), bm(B_RDY), "R8 shifter busy");
        shift_busy = 0; brk_req = 1;
        push_exp(bm(B_RDY) | bm(B_EMP), bm(B_EMP), "R8 break pending");
        brk_req = 0; tx_en = 0;
        push_exp(bm(B_RDY) | bm(B_EMP), 33'h0, "R8 disabled");

        // R9 DMA buffer mirror
        rxdma_full = 1;
        push_exp(bm(B_RXB), bm(B_RXB), "R9 full high");
        rxdma_full = 0;
        push_exp(bm(B_RXB), 33'h0, "R9 full low");

        // R4 error group
        fire(E_PAR); fire(E_FRM); fire(E_OVR); fire(E_BRK);
        push_exp(errs, errs, "R4 errors set");
        step(5);
        fire(E_RNAK);
        push_exp(errs, errs, "R4 errors survive nack reset");
        fire(E_RERR);
        push_exp(errs, 33'h0, "R4 errors cleared");

        // R5 NACK
        fire(E_NAK);
        push_exp(bm(B_NAK), bm(B_NAK), "R5 nack set");
        fire(E_RERR);
        push_exp(bm(B_NAK), bm(B_NAK), "R5 nack survives error reset");
        fire(E_RNAK);
        push_exp(bm(B_NAK), 33'h0, "R5 nack cleared");

        // R6 shared bit
        mode_sel = 4'h0;
        fire(E_UND);
        push_exp(bm(B_SHR), 33'h0, "R6 underrun ignored in normal mode");
        fire(E_REP);
        push_exp(bm(B_SHR), bm(B_SHR), "R6 repeat sets in normal mode");
        fire(E_RERR);
        push_exp(bm(B_SHR), 33'h0, "R6 cleared normal");
        mode_sel = 4'hF;
        fire(E_REP);
        push_exp(bm(B_SHR), 33'h0, "R6 repeat ignored in spi slave");
        fire(E_UND);
        push_exp(bm(B_SHR), bm(B_SHR), "R6 underrun sets in spi slave");
        fire(E_RERR);
        push_exp(bm(B_SHR), 33'h0, "R6 cleared spi slave");
        mode_sel = 4'h0;

        // R7 timeout
        fire(E_TE);
        push_exp(bm(B_TMO), 33'h0, "R7 expiry without start");
        fire(E_TS); fire(E_TE);
        push_exp(bm(B_TMO), bm(B_TMO), "R7 expiry after start");
        fire(E_TE);
        push_exp(bm(B_TMO), bm(B_TMO), "R7 flag holds");
        fire(E_TS);
        push_exp(bm(B_TMO), 33'h0, "R7 next start clears");
        tmo_zero = 1;
        fire(E_TS); fire(E_TE);
        push_exp(bm(B_TMO), 33'h0, "R7 zero value blocks");
        tmo_zero = 0;

        // R1 / R3 modem path latency on ri
        ri_pin = 1;
        step(1);
        push_exp(bm(B_RIL) | bm(B_RIC), 33'h0, "R3 after first edge");
        step(1);
        push_exp(bm(B_RIL) | bm(B_RIC), bm(B_RIL), "R3 level after second edge");
        step(1);
        push_exp(bm(B_RIC), bm(B_RIC), "R1 ri change after third edge");

        // R2 hold and clear
        step(5);
        push_exp(bm(B_RIC), bm(B_RIC), "R2 change holds without read");
        fire(E_RERR);
        push_exp(bm(B_RIC), bm(B_RIC), "R2 error reset leaves change");
        fire(E_RD);
        push_exp(bm(B_RIC), 33'h0, "R2 read clears change");

        // R1 other lanes
        cts_pin = 1; dcd_pin = 1; dsr_pin = 1;
        step(3);
        push_exp(bm(B_CTS) | bm(B_DCD) | bm(B_DSR), bm(B_CTS) | bm(B_DCD) | bm(B_DSR),
                 "R1 cts dcd dsr change");
        fire(E_RD);
        push_exp(bm(B_CTS) | bm(B_DCD) | bm(B_DSR), 33'h0, "R2 read clears three lanes");

        // R10 set wins: modem edge with read in same cycle
        ri_pin = 0;
        step(2);
        rd_en = 1;
        step(1);
        rd_en = 0;
        push_exp(bm(B_RIC) | bm(B_RIL), bm(B_RIC), "R10 edge beats read");
        fire(E_RD);
        push_exp(bm(B_RIC), 33'h0, "R10 later read clears");

        // R10 set wins: error event with error reset
        rx_parity_err = 1; rst_err_cmd = 1;
        step(1);
        rx_parity_err = 0; rst_err_cmd = 0;
        push_exp(bm(B_PAR), bm(B_PAR), "R10 parity beats reset");

        // R11 interrupt mask
        push_exp(bm(B_IRQ), 33'h0, "R11 masked off");
        mask_we = 1; mask_wdata = 32'h0000_0010;
        step(1);
        mask_we = 0;
        push_exp(bm(B_IRQ), bm(B_IRQ), "R11 parity enabled");
        fire(E_RERR);
        push_exp(bm(B_IRQ), 33'h0, "R11 cleared source");
        mask_we = 1; mask_wdata = 32'h0000_0001;
        step(1);
        mask_we = 0; tx_en = 1;
        push_exp(bm(B_IRQ), bm(B_IRQ), "R11 ready enabled");
        hold_busy = 1;
        push_exp(bm(B_IRQ), 33'h0, "R11 ready drops");
        hold_busy = 0; tx_en = 0;

        step(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule